// File: doc/BRIEF.md
# Frame-Aligned Clock-Crossing Pixel Buffer

This block moves pixel words from a camera-side parallel video port into the clock domain of a display timing generator. The camera side presents frame, line and pixel qualifiers with a pixel word on its own clock. The display side presents its own frame, line and pixel qualifiers on a second clock and receives pixel words one cycle later. Between the two sits an inferred dual-port RAM of `DEPTH` words, each `PIX_W` bits wide.

Each side keeps its own address, and that address restarts at zero on the rising edge of its own frame qualifier. No full or empty flags are used. When the RAM holds less than a whole frame (`PARTIAL = 1`), both addresses wrap inside the buffer. At each output frame start the read side stalls. It resumes at address zero once the input frame start has crossed into the read domain, so the output trails the input inside the same frame. Neither side can exert back-pressure: the camera qualifier acts as a valid with no ready, and `out_pix_valid` is a valid with no ready. The display side has to take each word in the cycle it is presented.

Top module: `vid_frame_xbuf`

## Requirements
- R1: A pixel is written on the input clock only when `in_fv`, `in_lv` and `in_dv` are all high. A word offered with `in_lv` or `in_fv` low is not stored and cannot later be read back.
- R2: On the first input-clock edge where `in_fv` is sampled high after being low, the write address restarts at zero. A pixel accepted on that edge goes to address 0, and later accepted pixels go to 1, 2, and so on.
- R3: A read takes place on the output clock only when `out_fv`, `out_lv` and `out_dv` are all high and the read side is enabled. In full-frame mode the read side is always enabled.
- R4: `out_pix_valid` goes high exactly one output-clock cycle after each read. `out_pix` then carries the word stored at the read address. `out_pix_valid` is low in every other cycle.
- R5: On the first output-clock edge where `out_fv` is sampled high after being low, the read address restarts at zero.
- R6: Both addresses step from `DEPTH-1` back to 0.
- R7: With `PARTIAL = 1`, an output frame start disables reads. The read side is enabled again, and its address cleared, only by an input frame start seen in the read domain. That event takes priority if both fall on the same edge.
- R8: An input frame start reaches the read side through a two-stage synchroniser. It takes effect on the second output-clock edge after the first output-clock edge that samples `in_fv` high, with `in_fv` having been low on the edge before that.
- R9: Each domain has an active-high synchronous reset. After reset `out_pix_valid` is low, both addresses are zero and, in partial mode, reads are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Camera pixel clock |
| in_rst | input | 1 | Synchronous reset, input domain, active high |
| in_fv | input | 1 | Input frame qualifier |
| in_lv | input | 1 | Input line qualifier |
| in_dv | input | 1 | Input pixel qualifier |
| in_pix | input | PIX_W | Input pixel word |
| out_clk | input | 1 | Display timing clock |
| out_rst | input | 1 | Synchronous reset, output domain, active high |
| out_fv | input | 1 | Output frame qualifier from the timing generator |
| out_lv | input | 1 | Output line qualifier |
| out_dv | input | 1 | Output pixel request |
| out_pix | output | PIX_W | Pixel word read from the buffer |
| out_pix_valid | output | 1 | `out_pix` holds a word read on the previous edge |

## Verification
The bench offers pixels with the line or frame qualifier low. A design that stored them would return marker words where frame data belongs. It runs output frames longer than the buffer and input frames of twice the depth, so an address that failed to wrap, or to restart at its own frame edge, would return stale or shifted pixels. It starts an output frame with no input frame following, and then one where the input frame comes a few cycles after the output frame. A partial-mode design that did not hold, or that released one cycle early or late after the synchroniser, would present valid words in the wrong cycles or from the wrong address.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  // Frame, line and pixel qualifiers of one video port.
  typedef struct packed {
    logic fv;
    logic lv;
    logic dv;
  } vid_ctl_t;
endpackage

// File: rtl/vfb_dpram.sv
module vfb_dpram #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vfb_wr_ctrl.sv
module vfb_wr_ctrl
  import vfb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  vid_ctl_t      ctl,
  output logic          we,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          fv_q;
  logic [AW-1:0] ptr;
  logic          sof;
  logic          accept;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  assign sof    = ctl.fv & ~fv_q;
  assign accept = ctl.fv & ctl.lv & ctl.dv;
  assign addr   = sof ? '0 : ptr;
  assign we     = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_q <= 1'b0;
      ptr  <= '0;
    end else begin
      fv_q <= ctl.fv;
      ptr  <= accept ? step(addr) : addr;
    end
  end

  // R1
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.dv |-> !we);

  // R2
  wr_frame_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.fv && !$past(ctl.fv) && we) |-> (addr == '0));

  // R6
  wr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == LAST) |=> (!we || addr == '0));
endmodule

// File: rtl/vfb_fs_sync.sv
module vfb_fs_sync (
  input  logic clk,
  input  logic rst,
  input  logic fv_async,
  output logic sof_pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= fv_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign sof_pulse = s2 & ~s3;

  // R8
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> !sof_pulse);
endmodule

// File: rtl/vfb_rd_ctrl.sv
module vfb_rd_ctrl
  import vfb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int AW      = 4,
  parameter bit PARTIAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  vid_ctl_t      ctl,
  input  logic          isof,
  output logic          re,
  output logic [AW-1:0] addr,
  output logic          out_valid
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          fv_q;
  logic [AW-1:0] ptr;
  logic          osof;
  logic          accept;
  logic          go_eff;
  logic          restart;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  assign osof   = ctl.fv & ~fv_q;
  assign accept = ctl.fv & ctl.lv & ctl.dv;

  generate
    if (PARTIAL) begin : g_align
      logic go;
      assign go_eff  = isof ? 1'b1 : (osof ? 1'b0 : go);
      assign restart = osof | isof;
      always_ff @(posedge clk) begin
        if (rst) go <= 1'b0;
        else     go <= go_eff;
      end

      // R7
      hold_until_input_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.fv && !$past(ctl.fv) && !isof) |=> !out_valid);
    end else begin : g_free
      assign go_eff  = 1'b1;
      assign restart = osof;
    end
  endgenerate

  assign addr = restart ? '0 : ptr;
  assign re   = accept & go_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_q      <= 1'b0;
      ptr       <= '0;
      out_valid <= 1'b0;
    end else begin
      fv_q      <= ctl.fv;
      ptr       <= re ? step(addr) : addr;
      out_valid <= re;
    end
  end

  // R3
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl.fv && ctl.lv && ctl.dv) |=> !out_valid);
endmodule

// File: rtl/vid_frame_xbuf.sv
module vid_frame_xbuf
  import vfb_pkg::*;
#(
  parameter int PIX_W   = 20,
  parameter int DEPTH   = 16,
  parameter bit PARTIAL = 1'b1
) (
  input  logic             in_clk,
  input  logic             in_rst,
  input  logic             in_fv,
  input  logic             in_lv,
  input  logic             in_dv,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             out_clk,
  input  logic             out_rst,
  input  logic             out_fv,
  input  logic             out_lv,
  input  logic             out_dv,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_pix_valid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  vid_ctl_t      wctl, rctl;
  logic          we, re, isof;
  logic [AW-1:0] waddr, raddr;

  assign wctl = '{fv: in_fv,  lv: in_lv,  dv: in_dv};
  assign rctl = '{fv: out_fv, lv: out_lv, dv: out_dv};

  vfb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(in_clk), .rst(in_rst), .ctl(wctl), .we(we), .addr(waddr)
  );

  generate
    if (PARTIAL) begin : g_sync
      vfb_fs_sync u_sync (
        .clk(out_clk), .rst(out_rst), .fv_async(in_fv), .sof_pulse(isof)
      );
    end else begin : g_nosync
      assign isof = 1'b0;
    end
  endgenerate

  vfb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PARTIAL(PARTIAL)) u_rd (
    .clk(out_clk), .rst(out_rst), .ctl(rctl), .isof(isof),
    .re(re), .addr(raddr), .out_valid(out_pix_valid)
  );

  vfb_dpram #(.W(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(in_clk), .we(we), .waddr(waddr), .wdata(in_pix),
    .rclk(out_clk), .re(re), .raddr(raddr), .rdata(out_pix)
  );
endmodule

// File: tb/tb_vid_frame_xbuf.sv
module tb_vid_frame_xbuf;
  localparam int PIX_W = 20;
  localparam int DEPTH = 16;

  logic in_clk = 0, out_clk = 0;
  logic in_rst = 1, out_rst = 1;
  logic in_fv = 0, in_lv = 0, in_dv = 0;
  logic [PIX_W-1:0] in_pix = '0;
  logic out_fv = 0, out_lv = 0, out_dv = 0;
  logic [PIX_W-1:0] pix_p, pix_f;
  logic v_p, v_f;

  int checks = 0, errors = 0;
  string tag = "R9";

  initial forever #5 in_clk = ~in_clk;
  initial begin #5; forever #5 out_clk = ~out_clk; end

  vid_frame_xbuf #(.PIX_W(PIX_W), .DEPTH(DEPTH), .PARTIAL(1'b1)) dut (
    .in_clk(in_clk), .in_rst(in_rst), .in_fv(in_fv), .in_lv(in_lv),
    .in_dv(in_dv), .in_pix(in_pix), .out_clk(out_clk), .out_rst(out_rst),
    .out_fv(out_fv), .out_lv(out_lv), .out_dv(out_dv),
    .out_pix(pix_p), .out_pix_valid(v_p));

  vid_frame_xbuf #(.PIX_W(PIX_W), .DEPTH(DEPTH), .PARTIAL(1'b0)) dut_full (
    .in_clk(in_clk), .in_rst(in_rst), .in_fv(in_fv), .in_lv(in_lv),
    .in_dv(in_dv), .in_pix(in_pix), .out_clk(out_clk), .out_rst(out_rst),
    .out_fv(out_fv), .out_lv(out_lv), .out_dv(out_dv),
    .out_pix(pix_f), .out_pix_valid(v_f));

  // Reference model: written words and the expectations per mode (0 partial, 1 full)
  int  mem   [DEPTH];
  bit  known [DEPTH];
  int  wptr = 0;
  bit  wfv_prev = 0;
  int  rptr  [2];
  bit  rgo   [2];
  bit  exp_v [2];
  int  exp_d [2];
  bit  exp_k [2];
  bit  ofv_prev = 0;
  bit  seen1 = 0, seen2 = 0, seen3 = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    for (int m = 0; m < 2; m++) begin
      rptr[m] = 0; rgo[m] = 0; exp_v[m] = 0; exp_d[m] = 0; exp_k[m] = 0;
    end
  end

  always @(posedge in_clk) begin
    if (in_rst) begin
      wptr = 0; wfv_prev = 0;
    end else begin
      if (in_fv && !wfv_prev) wptr = 0;
      if (in_fv && in_lv && in_dv) begin
        mem[wptr] = int'(in_pix); known[wptr] = 1;
        wptr = (wptr + 1) % DEPTH;
      end
      wfv_prev = in_fv;
    end
  end

  always @(posedge out_clk) begin
    if (out_rst) begin
      ofv_prev = 0; seen1 = 0; seen2 = 0; seen3 = 0;
      for (int m = 0; m < 2; m++) begin rptr[m] = 0; rgo[m] = 0; exp_v[m] = 0; end
    end else begin
      bit osof, isof, want;
      osof = out_fv && !ofv_prev;
      isof = seen2 && !seen3;
      want = out_fv && out_lv && out_dv;
      for (int m = 0; m < 2; m++) begin
        if (osof) begin rptr[m] = 0; rgo[m] = (m == 1); end
        if (isof && m == 0) begin rptr[m] = 0; rgo[m] = 1; end
        if (m == 1) rgo[m] = 1;
        exp_v[m] = want && rgo[m];
        if (exp_v[m]) begin
          exp_d[m] = mem[rptr[m]]; exp_k[m] = known[rptr[m]];
          rptr[m] = (rptr[m] + 1) % DEPTH;
        end
      end
      seen3 = seen2; seen2 = seen1; seen1 = in_fv;
      ofv_prev = out_fv;
    end
  end

  // Compare away from the edge, every output cycle
  initial forever begin
    @(posedge out_clk); #3;
    for (int m = 0; m < 2; m++) begin
      logic v;
      logic [PIX_W-1:0] d;
      v = (m == 0) ? v_p : v_f;
      d = (m == 0) ? pix_p : pix_f;
      checks++;
      if (v !== exp_v[m]) begin
        errors++;
        $display("FAIL %s (R4 valid) mode %0d: got %0b expected %0b at %0t", tag, m, v, exp_v[m], $time);
      end
      if (exp_v[m] && exp_k[m]) begin
        checks++;
        if (d !== PIX_W'(exp_d[m])) begin
          errors++;
          $display("FAIL %s (R4 data) mode %0d: got %h expected %h at %0t", tag, m, d, PIX_W'(exp_d[m]), $time);
        end
      end
    end
  end

  task automatic wcyc(input bit fv, input bit lv, input bit dv, input int pix);
    @(posedge in_clk); #2;
    in_fv = fv; in_lv = lv; in_dv = dv; in_pix = PIX_W'(pix);
  endtask

  task automatic rcyc(input bit fv, input bit lv, input bit dv);
    @(posedge out_clk); #2;
    out_fv = fv; out_lv = lv; out_dv = dv;
  endtask

  // R1 markers 'hBAD offered outside line/frame must never come back
  task automatic wr_frame(input int base, input int lines, input int ppl);
    wcyc(1, 0, 0, 0);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ppl; p++) begin
        wcyc(1, 1, 1, base + l * ppl + p);
        if (p == 3) wcyc(1, 1, 0, 'hDEAD);
      end
      wcyc(1, 0, 1, 'hBAD);
    end
    wcyc(0, 0, 1, 'hBAD);
    wcyc(0, 0, 0, 0);
    wcyc(0, 0, 0, 0);
  endtask

  task automatic rd_frame(input int lines, input int ppl, input bit gaps);
    rcyc(1, 0, 0);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ppl; p++) begin
        rcyc(1, 1, 1);
        if (gaps && p == 2) rcyc(1, 1, 0);
      end
      rcyc(1, 0, 0);
      rcyc(1, 0, 1);
    end
    rcyc(0, 0, 1);
    rcyc(0, 0, 0);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state is compared cycle by cycle by the model
    repeat (4) wcyc(0, 0, 0, 0);
    fork
      begin @(posedge in_clk); #2; in_rst = 0; end
      begin @(posedge out_clk); #2; out_rst = 0; end
    join
    repeat (3) rcyc(0, 0, 0);

    tag = "R1/R2";
    wr_frame('h100, 1, 12);
    repeat (3) rcyc(0, 0, 0);

    // Full mode reads the stored frame; partial mode holds with no input frame
    tag = "R3/R5/R7";
    rd_frame(1, 12, 1'b1);
    rd_frame(1, 12, 1'b0);

    // Input frame starts after the output frame: alignment and wrap
    tag = "R6/R7/R8";
    fork
      rd_frame(2, 16, 1'b0);
      begin repeat (4) wcyc(0, 0, 0, 0); wr_frame('h200, 2, 16); end
    join

    tag = "R6/R8";
    fork
      rd_frame(3, 12, 1'b1);
      begin repeat (2) wcyc(0, 0, 0, 0); wr_frame('h300, 2, 16); end
    join

    // R9 mid-run reset of the read side clears valid and the enable
    tag = "R9";
    rcyc(0, 0, 0);
    @(posedge out_clk); #2; out_rst = 1;
    repeat (2) rcyc(0, 0, 0);
    @(posedge out_clk); #2; out_rst = 0;
    rd_frame(1, 8, 1'b0);

    repeat (5) rcyc(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule